// File: doc/BRIEF.md
# External Interrupt Line Controller

The block watches sixteen external interrupt lines, each fed from one of up to nine general-purpose I/O ports. Line N can only see pin N of whichever port its selector picks. The selected level is brought into the clock domain by two flops. It is then compared with its value one cycle earlier to find rising and falling transitions. Each line has its own rising and falling enables. An enabled transition latches a per-line pending flag, which software clears by writing a one to it.

Two independent per-line masks route the lines. The interrupt mask lets a pending flag drive the shared level interrupt output. The event mask lets the transition itself drive a one-cycle event pulse, whatever the pending flags hold. Software configures and inspects the block over a single-cycle synchronous register bus. Writes are captured on the clock edge, and the read data follows the address combinationally.

Top module: `xint_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and `evt_o` is low. So every line starts masked, with no trigger enabled and port code 0 selected.
- R2: Line N samples `port_pins[P*16+N]`, where P is the 4-bit code in selector register N/4 (address 8 + N/4) at bits 4*(N mod 4)+3 down to 4*(N mod 4). Port codes run 0 to 8 for ports A to I. A transition on pin N of any other port has no effect on line N.
- R3: A selector code from 9 to 15 selects constant zero, so no pin level can set that line's pending flag.
- R4: With bit N set at address 0 (rising enables), a low-to-high change on the selected pin applied after clock edge k sets pending bit N at edge k+3.
- R5: With bit N set at address 1 (falling enables), a high-to-low change sets pending bit N with the same latency. A rising change on a line with only the falling enable set leaves the flag clear.
- R6: With both enables set for a line, each change in either direction sets its pending flag.
- R7: Writing to address 4 (pending) clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. Reading address 4 returns the flags in bits 15:0.
- R8: If an enabled transition is detected in the same cycle that a write clears that line's flag, the flag stays set.
- R9: `irq_o` is high exactly when some line has its pending flag set and its bit set at address 2 (interrupt mask). A pending line whose interrupt mask bit is clear leaves `irq_o` low.
- R10: `evt_o` is high for exactly the one cycle between edges k+2 and k+3 when a detected transition occurs on a line whose bit is set at address 3 (event mask). The pulse still occurs when that line's pending flag is already set, and no pulse occurs for a line whose event mask bit is clear.
- R11: Rewriting a line's selector never sets its pending flag by itself, even when the old and new pins sit at different levels. Transitions on the new pin are detected afterwards.
- R12: The register map is: enables at 0 and 1, masks at 2 and 3, pending at 4 and selectors at 8 to 11. Each register reads back what was last written in bits 15:0, and bits 31:16 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pins | input | 144 | Pin levels, port P pin N at bit P*16+N |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt: any pending and unmasked line |
| evt_o | output | 1 | One-cycle event pulse |

## Verification
Each trigger mode is driven with both a rising and a falling change. This separates the rising-only, falling-only and both-edge lines, and shows that a change in the disabled direction is ignored. Pin changes on a port the line does not select, on a line set to an out-of-range code, and on port code 8 confirm that the selector decodes the right field and the full code range. The mask cases cover event-only and neither. Together with a second transition while the flag is still pending, they separate the level interrupt from the event pulse. A clear write timed to land on the edge-detect cycle, and a selector swap between pins at opposite levels, cover the set-over-clear and no-false-edge corners.

// File: rtl/xint_pkg.sv
package xint_pkg;

    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_RISE  = 4'h0;
    localparam logic [ADDR_W-1:0] A_FALL  = 4'h1;
    localparam logic [ADDR_W-1:0] A_IMASK = 4'h2;
    localparam logic [ADDR_W-1:0] A_EMASK = 4'h3;
    localparam logic [ADDR_W-1:0] A_PEND  = 4'h4;
    localparam logic [ADDR_W-1:0] A_SEL0  = 4'h8;

endpackage

// File: rtl/xint_line.sv
module xint_line #(
    parameter int unsigned NUM_PORTS = 9,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned BLANK_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_pins,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 rise_en,
    input  logic                 fall_en,
    output logic                 edge_hit
);

    localparam int unsigned BLK_W = $clog2(BLANK_CYC + 1);

    typedef struct packed {
        logic             sync1;
        logic             sync2;
        logic             hist;
        logic [BLK_W-1:0] blank;
        logic [SEL_W-1:0] sel_prev;
    } line_st_t;

    line_st_t st_d, st_q;
    logic     raw;
    logic     quiet;

    // Port mux: codes beyond the port count give constant zero.
    always_comb begin
        raw = 1'b0;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            if (int'(sel) == p) raw = port_pins[p];
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.sync1    = raw;
        st_d.sync2    = st_q.sync1;
        st_d.hist     = st_q.sync2;
        st_d.sel_prev = sel;
        if (sel != st_q.sel_prev) begin
            st_d.blank = BLK_W'(BLANK_CYC);
        end else if (st_q.blank != '0) begin
            st_d.blank = st_q.blank - 1'b1;
        end
        // Hold detection off until the new source has reached the history flop.
        quiet    = (st_q.blank != '0) || (sel != st_q.sel_prev);
        edge_hit = !quiet &&
                   ((rise_en && st_q.sync2 && !st_q.hist) ||
                    (fall_en && !st_q.sync2 && st_q.hist));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SEL_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel) |=> !edge_hit) else $error("selector change produced an edge"); // R11

endmodule

// File: rtl/xint_regs.sv
module xint_regs
    import xint_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 16,
    parameter int unsigned SEL_W       = 4,
    parameter int unsigned SEL_PER_REG = 4,
    parameter int unsigned DATA_W      = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_LINES-1:0]       edge_hit,
    output logic [NUM_LINES-1:0]       rise_en,
    output logic [NUM_LINES-1:0]       fall_en,
    output logic [NUM_LINES-1:0]       irq_mask,
    output logic [NUM_LINES-1:0]       evt_mask,
    output logic [NUM_LINES-1:0]       pend,
    output logic [NUM_LINES*SEL_W-1:0] sel_flat
);

    localparam int unsigned FIELD_BITS = SEL_W * SEL_PER_REG;

    typedef struct packed {
        logic [NUM_LINES-1:0]       rise;
        logic [NUM_LINES-1:0]       fall;
        logic [NUM_LINES-1:0]       imask;
        logic [NUM_LINES-1:0]       emask;
        logic [NUM_LINES-1:0]       pend;
        logic [NUM_LINES*SEL_W-1:0] sel;
    } reg_st_t;

    reg_st_t              rf_d, rf_q;
    logic [NUM_LINES-1:0] clr_mask;

    generate
        if (DATA_W > NUM_LINES && DATA_W > FIELD_BITS) begin : g_spare
            localparam int unsigned LO = (NUM_LINES > FIELD_BITS) ? NUM_LINES : FIELD_BITS;
            logic unused_wdata;
            assign unused_wdata = ^bus_wdata[DATA_W-1:LO];
        end
    endgenerate

    always_comb begin
        rf_d     = rf_q;
        clr_mask = '0;
        if (bus_we) begin
            case (bus_addr)
                A_RISE:  rf_d.rise  = bus_wdata[NUM_LINES-1:0];
                A_FALL:  rf_d.fall  = bus_wdata[NUM_LINES-1:0];
                A_IMASK: rf_d.imask = bus_wdata[NUM_LINES-1:0];
                A_EMASK: rf_d.emask = bus_wdata[NUM_LINES-1:0];
                A_PEND:  clr_mask   = bus_wdata[NUM_LINES-1:0];
                default: ;
            endcase
            for (int n = 0; n < int'(NUM_LINES); n++) begin
                if (int'(bus_addr) == int'(A_SEL0) + n / int'(SEL_PER_REG)) begin
                    rf_d.sel[n*SEL_W +: SEL_W] =
                        bus_wdata[(n % int'(SEL_PER_REG))*SEL_W +: SEL_W];
                end
            end
        end
        // A detected edge wins over a same-cycle clear.
        rf_d.pend = (rf_q.pend & ~clr_mask) | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RISE:  bus_rdata[NUM_LINES-1:0] = rf_q.rise;
            A_FALL:  bus_rdata[NUM_LINES-1:0] = rf_q.fall;
            A_IMASK: bus_rdata[NUM_LINES-1:0] = rf_q.imask;
            A_EMASK: bus_rdata[NUM_LINES-1:0] = rf_q.emask;
            A_PEND:  bus_rdata[NUM_LINES-1:0] = rf_q.pend;
            default: ;
        endcase
        for (int n = 0; n < int'(NUM_LINES); n++) begin
            if (int'(bus_addr) == int'(A_SEL0) + n / int'(SEL_PER_REG)) begin
                bus_rdata[(n % int'(SEL_PER_REG))*SEL_W +: SEL_W] = rf_q.sel[n*SEL_W +: SEL_W];
            end
        end
    end

    assign rise_en  = rf_q.rise;
    assign fall_en  = rf_q.fall;
    assign irq_mask = rf_q.imask;
    assign evt_mask = rf_q.emask;
    assign pend     = rf_q.pend;
    assign sel_flat = rf_q.sel;

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PEND) |=>
        ((pend & $past(bus_wdata[NUM_LINES-1:0]) & ~$past(edge_hit)) == '0))
        else $error("pending flag survived a clear"); // R7

    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PEND && bus_wdata[NUM_LINES-1:0] == '0) |=>
        ((pend & $past(pend)) == $past(pend)))
        else $error("zero write dropped a flag"); // R7

    AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((pend & $past(edge_hit)) == $past(edge_hit)))
        else $error("edge did not latch"); // R8

    AST_PEND_FROM_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(edge_hit)) == '0))
        else $error("pending flag set without an edge"); // R4

endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 16,
    parameter int unsigned NUM_PORTS   = 9,
    parameter int unsigned SEL_W       = 4,
    parameter int unsigned SEL_PER_REG = 4,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned BLANK_CYC   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic                           irq_o,
    output logic                           evt_o
);

    logic [NUM_LINES-1:0]       edge_hit;
    logic [NUM_LINES-1:0]       rise_en;
    logic [NUM_LINES-1:0]       fall_en;
    logic [NUM_LINES-1:0]       irq_mask;
    logic [NUM_LINES-1:0]       evt_mask;
    logic [NUM_LINES-1:0]       pend;
    logic [NUM_LINES*SEL_W-1:0] sel_flat;

    xint_regs #(
        .NUM_LINES   (NUM_LINES),
        .SEL_W       (SEL_W),
        .SEL_PER_REG (SEL_PER_REG),
        .DATA_W      (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .edge_hit  (edge_hit),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .irq_mask  (irq_mask),
        .evt_mask  (evt_mask),
        .pend      (pend),
        .sel_flat  (sel_flat)
    );

    generate
        for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
            logic [NUM_PORTS-1:0] line_pins;
            for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pin
                assign line_pins[p] = port_pins[p*NUM_LINES + n];
            end
            xint_line #(
                .NUM_PORTS (NUM_PORTS),
                .SEL_W     (SEL_W),
                .BLANK_CYC (BLANK_CYC)
            ) u_line (
                .clk       (clk),
                .rst_n     (rst_n),
                .port_pins (line_pins),
                .sel       (sel_flat[n*SEL_W +: SEL_W]),
                .rise_en   (rise_en[n]),
                .fall_en   (fall_en[n]),
                .edge_hit  (edge_hit[n])
            );
        end
    endgenerate

    assign irq_o = |(pend & irq_mask);
    assign evt_o = |(edge_hit & evt_mask);

endmodule

// File: tb/xint_ctrl_bench.sv
module xint_ctrl_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [143:0] pins = '0;
    logic         bus_we = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_o;
    logic         evt_o;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int          when;
        int          kind;   // 0 read data, 1 irq, 2 event
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    xint_ctrl u_xint_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_pins (pins),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .evt_o     (evt_o)
    );

    // Monitor: pops due items and compares them at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].when <= cyc) begin
            item_t       it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {31'd0, irq_o};
                default: act = {31'd0, evt_o};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d actual=0x%08h expected=0x%08h at cycle %0d",
                         it.tag, it.kind, act, it.exp, cyc);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.when = cyc;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        push(0, e, tag);
        tick(1);
    endtask

    task automatic exp_irq(input logic e, input string tag);
        push(1, {31'd0, e}, tag);
    endtask

    task automatic exp_evt(input logic e, input string tag);
        push(2, {31'd0, e}, tag);
    endtask

    task automatic set_pin(input int p, input int n, input logic v);
        pins[p*16 + n] = v;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        logic [31:0] rise_v;
        rise_v = '0;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1: reset values
        foreach (sb_q[i]) ;
        for (int a = 0; a < 12; a++) begin
            if (a < 5 || a > 7) exp_rd(4'(a), 32'h0, "R1");
        end
        exp_irq(1'b0, "R1");
        exp_evt(1'b0, "R1");
        tick(1);

        // R2 R4 R9 R10 R12: line 3 on port C (code 2, bits 15:12 of address 8)
        wr(4'h8, 32'h0000_2000);
        rise_v = 32'h0008;
        wr(4'h0, rise_v);
        wr(4'h2, 32'h0008);
        wr(4'h3, 32'h0008);
        tick(4);
        exp_rd(4'h8, 32'h0000_2000, "R12");
        set_pin(0, 3, 1'b1);              // port A pin 3, not selected
        tick(5);
        exp_rd(4'h4, 32'h0, "R2");
        exp_irq(1'b0, "R2");
        set_pin(2, 3, 1'b1);
        tick(2);
        exp_evt(1'b1, "R10");
        tick(1);
        exp_evt(1'b0, "R10");
        exp_irq(1'b1, "R9");
        exp_rd(4'h4, 32'h0008, "R4");

        // R7: zero write keeps, one write clears
        wr(4'h4, 32'h0);
        exp_rd(4'h4, 32'h0008, "R7");
        wr(4'h4, 32'h0008);
        exp_rd(4'h4, 32'h0, "R7");
        exp_irq(1'b0, "R9");

        // R5: line 5 falling only, port A (default)
        wr(4'h1, 32'h0020);
        set_pin(0, 5, 1'b1);
        tick(5);
        exp_rd(4'h4, 32'h0, "R5");
        set_pin(0, 5, 1'b0);
        tick(3);
        exp_rd(4'h4, 32'h0020, "R5");
        wr(4'h4, 32'h0020);

        // R6: line 7 on port D, both directions
        wr(4'h9, 32'h0000_3000);
        rise_v = rise_v | 32'h0080;
        wr(4'h0, rise_v);
        wr(4'h1, 32'h00A0);
        tick(4);
        set_pin(3, 7, 1'b1);
        tick(3);
        exp_rd(4'h4, 32'h0080, "R6");
        wr(4'h4, 32'h0080);
        set_pin(3, 7, 1'b0);
        tick(3);
        exp_rd(4'h4, 32'h0080, "R6");
        wr(4'h4, 32'h0080);

        // R9 R10: line 9 event only
        rise_v = rise_v | 32'h0200;
        wr(4'h0, rise_v);
        wr(4'h3, 32'h0208);
        tick(2);
        set_pin(0, 9, 1'b1);
        tick(2);
        exp_evt(1'b1, "R10");
        tick(1);
        exp_evt(1'b0, "R10");
        exp_irq(1'b0, "R9");
        exp_rd(4'h4, 32'h0200, "R9");
        // second edge while still pending still pulses
        set_pin(0, 9, 1'b0);
        tick(4);
        set_pin(0, 9, 1'b1);
        tick(2);
        exp_evt(1'b1, "R10");
        tick(1);
        exp_evt(1'b0, "R10");
        wr(4'h4, 32'h0200);

        // R9 R10: line 10 with neither mask
        rise_v = rise_v | 32'h0400;
        wr(4'h0, rise_v);
        tick(2);
        set_pin(0, 10, 1'b1);
        tick(2);
        exp_evt(1'b0, "R10");
        tick(1);
        exp_irq(1'b0, "R9");
        exp_rd(4'h4, 32'h0400, "R9");
        wr(4'h4, 32'h0400);

        // R8: clear lands on the same edge that latches line 3
        set_pin(2, 3, 1'b0);
        tick(4);
        set_pin(2, 3, 1'b1);
        tick(2);
        wr(4'h4, 32'h0008);
        exp_rd(4'h4, 32'h0008, "R8");
        wr(4'h4, 32'h0008);
        exp_rd(4'h4, 32'h0, "R7");

        // R3: line 11 with code 12 (bits 15:12 of address 10)
        wr(4'hA, 32'h0000_C000);
        rise_v = rise_v | 32'h0800;
        wr(4'h0, rise_v);
        tick(4);
        for (int p = 0; p < 9; p++) set_pin(p, 11, 1'b1);
        tick(5);
        exp_rd(4'h4, 32'h0, "R3");
        exp_rd(4'hA, 32'h0000_C000, "R12");

        // R2: line 12 on port I (code 8, bits 3:0 of address 11)
        wr(4'hB, 32'h0000_0008);
        rise_v = rise_v | 32'h1000;
        wr(4'h0, rise_v);
        tick(4);
        set_pin(8, 12, 1'b1);
        tick(3);
        exp_rd(4'h4, 32'h1000, "R2");
        wr(4'h4, 32'h1000);

        // R11: line 13 swapped from port A (low) to port B (high)
        set_pin(1, 13, 1'b1);
        rise_v = rise_v | 32'h2000;
        wr(4'h0, rise_v);
        tick(4);
        wr(4'hB, 32'h0000_0018);
        tick(6);
        exp_rd(4'h4, 32'h0, "R11");
        set_pin(1, 13, 1'b0);
        tick(4);
        set_pin(1, 13, 1'b1);
        tick(3);
        exp_rd(4'h4, 32'h2000, "R11");
        wr(4'h4, 32'h2000);

        // R12: upper bits read as zero
        wr(4'h2, 32'hFFFF_FFFF);
        exp_rd(4'h2, 32'h0000_FFFF, "R12");
        wr(4'h2, 32'h0);
        exp_rd(4'h1, 32'h0000_00A0, "R12");

        tick(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule